// File: doc/BRIEF.md
# DMA Control and Status Register Unit

This block holds the shared control state of a four-channel DMA controller: one command byte, one mode byte per channel, a per-channel mask and a status byte. The status byte keeps one terminal-count flag per channel in its low half and one request flag per channel in its high half. A host reaches the unit through eight byte-wide control offsets selected by a 3-bit port address. Each offset either updates part of the state or starts an action. The transfer engine sits next to this unit. It consumes the mask, mode and request outputs and reports finished transfers through terminal-count pulses. Peripherals raise and drop their requests through separate hold and release pulses.

Every write takes effect at the clock edge where the write strobe is sampled. A read strobe loads the registered read data at its edge, so the value is valid from the following cycle. Reading the status byte returns its current contents and then clears only the terminal-count half. The byte-pointer clear strobe is a registered one-cycle pulse that tells the neighbouring address and count registers to restart their low/high byte sequence.

Top module: `dma_ctrl_regs`

## Requirements
- R1: After reset every mask bit is 1. Command, status, all mode bytes, read data and the pointer-clear strobe are 0.
- R2: A write at offset 0 loads the command register only when the data has no bit set other than bit 2, so only 0x00 and 0x04 are accepted. Any other value leaves the command unchanged.
- R3: A write at offset 1 selects a channel with data bits [1:0]. Data bit 2 sets (1) or clears (0) that channel's request flag, which is status bit 4+channel. The same write clears that channel's terminal-count flag, status bit channel.
- R4: A write at offset 2 sets (data bit 2 = 1) or clears (data bit 2 = 0) the mask bit of the channel in data bits [1:0]. The other mask bits are unchanged.
- R5: A write at offset 3 stores the whole data byte as the mode of the channel in data bits [1:0]. Mode output bits [8c+7:8c] belong to channel c. The other channels keep their modes.
- R6: A write at offset 6 clears all mask bits. A write at offset 7 loads the mask from data bits [3:0].
- R7: A write at offset 5 sets all mask bits and clears status and command. This overrides terminal-count and hold pulses in the same cycle and leaves the mode bytes unchanged.
- R8: `ptr_clr` is high for exactly the one cycle that follows a write at offset 4 or offset 5, and is low otherwise.
- R9: A read at offset 0 returns the status byte as it stood before the read edge. It then clears status bits [3:0] and keeps bits [7:4].
- R10: A read at offset 1 returns the mask in bits [3:0] with zero above. A read at any offset from 2 to 7 returns 0. The read data holds its last value while no read is strobed.
- R11: A terminal-count pulse on a channel sets that channel's status bit. It wins over a status read-clear or a software-request clear in the same cycle.
- R12: A hold pulse sets a channel's request flag and a release pulse clears it. Hold wins over release, and both win over a software-request write to the same channel in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 3 | Control port offset |
| cpu_wdata | input | DW | Write data |
| cpu_wr | input | 1 | Write strobe |
| cpu_rd | input | 1 | Read strobe |
| tc_set | input | NCH | Terminal-count set pulse per channel |
| req_hold | input | NCH | External request raise pulse per channel |
| req_release | input | NCH | External request drop pulse per channel |
| cpu_rdata | output | DW | Registered read data |
| cmd_o | output | DW | Command register |
| mask_o | output | NCH | Channel mask bits |
| mode_o | output | NCH*DW | Mode byte of every channel |
| req_o | output | NCH | Request flags (status high half) |
| ptr_clr | output | 1 | Byte-pointer clear pulse |

## Verification
The bench builds the unit with its defaults: four channels and 8-bit data. With these values the status fills exactly one byte and every 2-bit channel select code names a real channel. Each channel field and each status half can therefore be reached and read back through the ports. The same-cycle collisions get their own directed cases: terminal count against read-clear, hold against release, hold against a software clear, and master clear against pending pulses.

// File: rtl/dma_ctrl_pkg.sv
package dma_ctrl_pkg;

  typedef enum logic [2:0] {
    OFS_CMD     = 3'd0,
    OFS_SWREQ   = 3'd1,
    OFS_MASK1   = 3'd2,
    OFS_MODE    = 3'd3,
    OFS_PTRCLR  = 3'd4,
    OFS_MCLR    = 3'd5,
    OFS_UNMASK  = 3'd6,
    OFS_MASKALL = 3'd7
  } ofs_e;

  // Only this command bit may be set in an accepted command word.
  localparam int CMD_OK_BIT = 2;

  typedef struct packed {
    logic cmd;
    logic swreq;
    logic mask1;
    logic mode;
    logic ptrclr;
    logic mclr;
    logic unmask;
    logic maskall;
  } wr_sel_t;

endpackage

// File: rtl/dma_ctrl_decode.sv
module dma_ctrl_decode
  import dma_ctrl_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          wr,
  input  logic [2:0]    addr,
  input  logic [DW-1:0] wdata,
  output wr_sel_t       sel
);
  logic [DW-1:0] bad_bits;

  always_comb begin
    bad_bits             = wdata;
    bad_bits[CMD_OK_BIT] = 1'b0;
  end

  always_comb begin
    sel         = '0;
    sel.cmd     = wr && (addr == OFS_CMD) && (bad_bits == '0);
    sel.swreq   = wr && (addr == OFS_SWREQ);
    sel.mask1   = wr && (addr == OFS_MASK1);
    sel.mode    = wr && (addr == OFS_MODE);
    sel.ptrclr  = wr && (addr == OFS_PTRCLR);
    sel.mclr    = wr && (addr == OFS_MCLR);
    sel.unmask  = wr && (addr == OFS_UNMASK);
    sel.maskall = wr && (addr == OFS_MASKALL);
  end
endmodule

// File: rtl/dma_ctrl_status.sv
module dma_ctrl_status #(
  parameter int NCH  = 4,
  parameter int CH_W = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            mclr,
  input  logic            swreq,
  input  logic [CH_W-1:0] sw_ch,
  input  logic            sw_set,
  input  logic            rd_clr,
  input  logic [NCH-1:0]  tc_set,
  input  logic [NCH-1:0]  hold,
  input  logic [NCH-1:0]  release_i,
  output logic [NCH-1:0]  tc_q,
  output logic [NCH-1:0]  req_q
);
  logic [NCH-1:0] tc_n, req_n;

  // Later statements take precedence: read-clear, software request,
  // external release, external hold, terminal-count set.
  always_comb begin
    tc_n  = tc_q;
    req_n = req_q;
    if (rd_clr) tc_n = '0;
    if (swreq) begin
      tc_n[sw_ch]  = 1'b0;
      req_n[sw_ch] = sw_set;
    end
    req_n = (req_n & ~release_i) | hold;
    tc_n  = tc_n | tc_set;
  end

  always_ff @(posedge clk) begin
    if (rst || mclr) begin
      tc_q  <= '0;
      req_q <= '0;
    end else begin
      tc_q  <= tc_n;
      req_q <= req_n;
    end
  end
endmodule

// File: rtl/dma_ctrl_cfg.sv
module dma_ctrl_cfg #(
  parameter int NCH  = 4,
  parameter int DW   = 8,
  parameter int CH_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mclr,
  input  logic              mask1_we,
  input  logic              unmask_we,
  input  logic              maskall_we,
  input  logic              mode_we,
  input  logic [DW-1:0]     wdata,
  output logic [NCH-1:0]    mask_q,
  output logic [NCH*DW-1:0] mode_flat
);
  logic [CH_W-1:0] ch;
  assign ch = wdata[CH_W-1:0];

  always_ff @(posedge clk) begin
    if (rst || mclr)    mask_q     <= '1;
    else if (unmask_we) mask_q     <= '0;
    else if (maskall_we) mask_q    <= wdata[NCH-1:0];
    else if (mask1_we)  mask_q[ch] <= wdata[2];
  end

  for (genvar g = 0; g < NCH; g++) begin : g_mode
    logic [DW-1:0] mode_q;
    always_ff @(posedge clk) begin
      if (rst)                                 mode_q <= '0;
      else if (mode_we && (ch == CH_W'(g)))    mode_q <= wdata;
    end
    assign mode_flat[g*DW +: DW] = mode_q;
  end
endmodule

// File: rtl/dma_ctrl_regs.sv
module dma_ctrl_regs
  import dma_ctrl_pkg::*;
#(
  parameter int NCH = 4,
  parameter int DW  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        cpu_addr,
  input  logic [DW-1:0]     cpu_wdata,
  input  logic              cpu_wr,
  input  logic              cpu_rd,
  input  logic [NCH-1:0]    tc_set,
  input  logic [NCH-1:0]    req_hold,
  input  logic [NCH-1:0]    req_release,
  output logic [DW-1:0]     cpu_rdata,
  output logic [DW-1:0]     cmd_o,
  output logic [NCH-1:0]    mask_o,
  output logic [NCH*DW-1:0] mode_o,
  output logic [NCH-1:0]    req_o,
  output logic              ptr_clr
);
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int SW   = 2 * NCH;

  wr_sel_t        sel;
  logic [NCH-1:0] tc_q;
  logic [SW-1:0]  stat_q;
  logic           rd_stat;

  dma_ctrl_decode #(.DW(DW)) u_dec (
    .wr(cpu_wr), .addr(cpu_addr), .wdata(cpu_wdata), .sel(sel)
  );

  assign rd_stat = cpu_rd && (cpu_addr == OFS_CMD);

  dma_ctrl_status #(.NCH(NCH), .CH_W(CH_W)) u_stat (
    .clk(clk), .rst(rst), .mclr(sel.mclr),
    .swreq(sel.swreq), .sw_ch(cpu_wdata[CH_W-1:0]), .sw_set(cpu_wdata[2]),
    .rd_clr(rd_stat), .tc_set(tc_set), .hold(req_hold),
    .release_i(req_release), .tc_q(tc_q), .req_q(req_o)
  );

  assign stat_q = {req_o, tc_q};

  dma_ctrl_cfg #(.NCH(NCH), .DW(DW), .CH_W(CH_W)) u_cfg (
    .clk(clk), .rst(rst), .mclr(sel.mclr),
    .mask1_we(sel.mask1), .unmask_we(sel.unmask), .maskall_we(sel.maskall),
    .mode_we(sel.mode), .wdata(cpu_wdata),
    .mask_q(mask_o), .mode_flat(mode_o)
  );

  always_ff @(posedge clk) begin
    if (rst || sel.mclr) cmd_o <= '0;
    else if (sel.cmd)    cmd_o <= cpu_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) ptr_clr <= 1'b0;
    else     ptr_clr <= sel.ptrclr || sel.mclr;
  end

  always_ff @(posedge clk) begin
    if (rst) cpu_rdata <= '0;
    else if (cpu_rd) begin
      case (cpu_addr)
        OFS_CMD:   cpu_rdata <= DW'(stat_q);
        OFS_SWREQ: cpu_rdata <= DW'(mask_o);
        default:   cpu_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/dma_ctrl_regs_chk.sv
module dma_ctrl_regs_chk #(
  parameter int NCH = 4,
  parameter int DW  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [2:0]        cpu_addr,
  input logic [DW-1:0]     cpu_wdata,
  input logic              cpu_wr,
  input logic              cpu_rd,
  input logic [NCH-1:0]    tc_set,
  input logic [NCH-1:0]    req_hold,
  input logic [NCH-1:0]    req_release,
  input logic [DW-1:0]     cmd_o,
  input logic [NCH-1:0]    mask_o,
  input logic [NCH-1:0]    req_o,
  input logic              ptr_clr,
  input logic [2*NCH-1:0]  status
);
  logic          mclr_w, ptr_w;
  logic [DW-1:0] cmd_bad;

  assign mclr_w  = cpu_wr && (cpu_addr == 3'd5);
  assign ptr_w   = cpu_wr && ((cpu_addr == 3'd4) || (cpu_addr == 3'd5));
  assign cmd_bad = cpu_wdata & ~DW'(4);

  p_cmd_reject_r2: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr && cpu_addr == 3'd0 && cmd_bad != '0) |=> $stable(cmd_o));

  p_mclr_r7: assert property (@(posedge clk) disable iff (rst)
    mclr_w |=> (mask_o == '1 && cmd_o == '0 && status == '0));

  p_ptr_hi_r8: assert property (@(posedge clk) disable iff (rst)
    ptr_w |=> ptr_clr);

  p_ptr_lo_r8: assert property (@(posedge clk) disable iff (rst)
    !ptr_w |=> !ptr_clr);

  p_rdclr_r9: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd && cpu_addr == 3'd0 && tc_set == '0 && !mclr_w)
      |=> (status[NCH-1:0] == '0));

  p_tc_wins_r11: assert property (@(posedge clk) disable iff (rst)
    (tc_set != '0 && !mclr_w)
      |=> ((status[NCH-1:0] & $past(tc_set)) == $past(tc_set)));

  p_hold_r12: assert property (@(posedge clk) disable iff (rst)
    (req_hold != '0 && !mclr_w)
      |=> ((req_o & $past(req_hold)) == $past(req_hold)));

  p_release_r12: assert property (@(posedge clk) disable iff (rst)
    ((req_release & ~req_hold) != '0)
      |=> ((req_o & $past(req_release & ~req_hold)) == '0));
endmodule

bind dma_ctrl_regs dma_ctrl_regs_chk #(.NCH(NCH), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
  .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .tc_set(tc_set), .req_hold(req_hold),
  .req_release(req_release), .cmd_o(cmd_o), .mask_o(mask_o),
  .req_o(req_o), .ptr_clr(ptr_clr), .status(stat_q)
);

// File: tb/test_dma_ctrl_regs.sv
module test_dma_ctrl_regs;
  localparam int NCH = 4;
  localparam int DW  = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [2:0]        cpu_addr = '0;
  logic [DW-1:0]     cpu_wdata = '0;
  logic              cpu_wr = 1'b0;
  logic              cpu_rd = 1'b0;
  logic [NCH-1:0]    tc_set = '0;
  logic [NCH-1:0]    req_hold = '0;
  logic [NCH-1:0]    req_release = '0;
  logic [DW-1:0]     cpu_rdata;
  logic [DW-1:0]     cmd_o;
  logic [NCH-1:0]    mask_o;
  logic [NCH*DW-1:0] mode_o;
  logic [NCH-1:0]    req_o;
  logic              ptr_clr;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dma_ctrl_regs #(.NCH(NCH), .DW(DW)) i_dma_ctrl_regs (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .tc_set(tc_set), .req_hold(req_hold),
    .req_release(req_release), .cpu_rdata(cpu_rdata), .cmd_o(cmd_o),
    .mask_o(mask_o), .mode_o(mode_o), .req_o(req_o), .ptr_clr(ptr_clr)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a);
    @(negedge clk);
    cpu_addr = a; cpu_rd = 1'b1;
    @(negedge clk);
    cpu_rd = 1'b0;
  endtask

  task automatic pulse(input logic [3:0] tc, input logic [3:0] hd, input logic [3:0] rl);
    @(negedge clk);
    tc_set = tc; req_hold = hd; req_release = rl;
    @(negedge clk);
    tc_set = '0; req_hold = '0; req_release = '0;
  endtask

  task automatic t_reset();
    chk("R1", "mask", mask_o, 4'hF);
    chk("R1", "cmd", cmd_o, 0);
    chk("R1", "modes", mode_o, 0);
    chk("R1", "req", req_o, 0);
    chk("R1", "ptr_clr", ptr_clr, 0);
    chk("R1", "rdata", cpu_rdata, 0);
    rd(3'd0);
    chk("R1", "status", cpu_rdata, 0);
  endtask

  task automatic t_command();
    wr(3'd0, 8'h04); chk("R2", "cmd accept 04", cmd_o, 8'h04);
    wr(3'd0, 8'h05); chk("R2", "cmd reject 05", cmd_o, 8'h04);
    wr(3'd0, 8'h80); chk("R2", "cmd reject 80", cmd_o, 8'h04);
    wr(3'd0, 8'h00); chk("R2", "cmd accept 00", cmd_o, 8'h00);
  endtask

  task automatic t_mode();
    wr(3'd3, 8'h56);
    chk("R5", "mode ch2", mode_o, 32'h0056_0000);
    wr(3'd3, 8'h93);
    chk("R5", "mode ch3", mode_o, 32'h9356_0000);
  endtask

  task automatic t_mask();
    wr(3'd6, 8'h00); chk("R6", "unmask all", mask_o, 4'h0);
    wr(3'd2, 8'h05); chk("R4", "set ch1", mask_o, 4'h2);
    wr(3'd2, 8'h07); chk("R4", "set ch3", mask_o, 4'hA);
    wr(3'd2, 8'h01); chk("R4", "clear ch1", mask_o, 4'h8);
    wr(3'd7, 8'hF5); chk("R6", "load mask", mask_o, 4'h5);
    rd(3'd1); chk("R10", "read mask", cpu_rdata, 8'h05);
    rd(3'd3); chk("R10", "read ofs3", cpu_rdata, 8'h00);
    repeat (2) @(negedge clk);
    chk("R10", "rdata held", cpu_rdata, 8'h00);
  endtask

  task automatic t_tc_read();
    pulse(4'b0101, 4'b0000, 4'b0000);
    rd(3'd0); chk("R11", "tc flags", cpu_rdata, 8'h05);
    rd(3'd0); chk("R9", "tc cleared by read", cpu_rdata, 8'h00);
    pulse(4'b0000, 4'b1000, 4'b0000);
    chk("R12", "hold ch3", req_o, 4'h8);
    rd(3'd0); chk("R9", "req read", cpu_rdata, 8'h80);
    rd(3'd0); chk("R9", "req kept", cpu_rdata, 8'h80);
  endtask

  task automatic t_swreq();
    pulse(4'b0010, 4'b0000, 4'b0000);
    wr(3'd1, 8'h05);
    chk("R3", "swreq set ch1", req_o, 4'hA);
    rd(3'd0); chk("R3", "tc1 cleared", cpu_rdata, 8'hA0);
    wr(3'd1, 8'h01);
    chk("R3", "swreq clear ch1", req_o, 4'h8);
  endtask

  task automatic t_race();
    @(negedge clk);
    cpu_addr = 3'd0; cpu_rd = 1'b1; tc_set = 4'b0100;
    @(negedge clk);
    cpu_rd = 1'b0; tc_set = '0;
    chk("R9", "read returns pre-edge", cpu_rdata, 8'h80);
    rd(3'd0); chk("R11", "tc beats read-clear", cpu_rdata, 8'h84);
    pulse(4'b0000, 4'b0001, 4'b0001);
    chk("R12", "hold beats release", req_o, 4'h9);
    pulse(4'b0000, 4'b0000, 4'b0001);
    chk("R12", "release ch0", req_o, 4'h8);
    @(negedge clk);
    cpu_addr = 3'd1; cpu_wdata = 8'h03; cpu_wr = 1'b1; req_hold = 4'b1000;
    @(negedge clk);
    cpu_wr = 1'b0; req_hold = '0;
    chk("R12", "hold beats sw clear", req_o, 4'h8);
    @(negedge clk);
    cpu_addr = 3'd1; cpu_wdata = 8'h03; cpu_wr = 1'b1; tc_set = 4'b1000;
    @(negedge clk);
    cpu_wr = 1'b0; tc_set = '0;
    rd(3'd0); chk("R11", "tc beats sw clear", cpu_rdata, 8'h08);
  endtask

  task automatic t_ptr();
    wr(3'd4, 8'h00);
    chk("R8", "ptr_clr pulse", ptr_clr, 1);
    @(negedge clk);
    chk("R8", "ptr_clr drops", ptr_clr, 0);
    wr(3'd2, 8'h00);
    chk("R8", "no pulse other offset", ptr_clr, 0);
  endtask

  task automatic t_mclr();
    wr(3'd0, 8'h04);
    wr(3'd6, 8'h00);
    pulse(4'b0000, 4'b0110, 4'b0000);
    @(negedge clk);
    cpu_addr = 3'd5; cpu_wr = 1'b1; tc_set = 4'b0011; req_hold = 4'b0001;
    @(negedge clk);
    cpu_wr = 1'b0; tc_set = '0; req_hold = '0;
    chk("R7", "mask set", mask_o, 4'hF);
    chk("R7", "cmd cleared", cmd_o, 0);
    chk("R7", "req cleared", req_o, 0);
    chk("R8", "ptr_clr on master clear", ptr_clr, 1);
    chk("R7", "modes kept", mode_o, 32'h9356_0000);
    rd(3'd0); chk("R7", "status cleared", cpu_rdata, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_command();
    t_mode();
    t_mask();
    t_tc_read();
    t_swreq();
    t_race();
    t_ptr();
    t_mclr();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule